// File: doc/BRIEF.md
# Single-Issue Load/Store Instruction Executor

This block is a small in-order core that runs a straight-line program from an instruction memory. It executes one instruction at a time. Each 32-bit instruction names one destination register, one operation, one source register and a 20-bit operand. The operand is either a signed constant or a word address. The core has sixteen 32-bit registers and an arithmetic unit that multiplies, adds, ANDs and ORs a register with the sign-extended operand. A load reads a data word at the address held in a register, and a return operation stops the core.

Both memories are synchronous read ports with a fixed latency of one cycle. The core raises a request with a word address, and the word is taken from the read-data input on the next clock edge. Neither port has back-pressure: the memory must return data in exactly the next cycle, and the core never issues a request it cannot consume. A debug port reads any register combinationally at any time. An active-low reset restarts the program from word 0 with every register cleared.

Top module: `lsx_core`

## Requirements
- R1: While reset is asserted, and right after it is released, the program counter is 0, every register reads 0 through the debug port and `halted` is low.
- R2: Instruction fields, from the MSB down: bits [31:28] select the destination register, bits [27:24] the operation, bits [23:20] the source register and bits [19:0] the operand.
- R3: Before use, the 20-bit operand is sign-extended to 32 bits as a two's-complement value (0x80000 is -524288 and 0x7FFFF is +524287).
- R4: Operation code 0 writes the low 32 bits of source × extended operand to the destination.
- R5: Operation code 1 writes source + extended operand to the destination.
- R6: Operation code 2 writes source AND extended operand, and operation code 3 writes source OR extended operand.
- R7: Operation code 4 issues a data read at the low 20 bits of the source register, ignores the operand field, and writes the returned word to the destination.
- R8: Operation code 15 raises `halted`. It stays high, and no further instruction or data request is made, until reset. Instructions after it are not executed.
- R9: Operation codes 5 to 14 change no register. The program counter still advances past them.
- R10: The program counter advances by one word per completed instruction. An arithmetic or no-op instruction takes 2 cycles, a load takes 3 cycles, and a return raises `halted` 2 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset / restart |
| imem_req | output | 1 | Instruction read request |
| imem_addr | output | 20 | Instruction word address (program counter) |
| imem_rdata | input | 32 | Instruction word, valid the cycle after a request |
| dmem_req | output | 1 | Data read request |
| dmem_addr | output | 20 | Data word address |
| dmem_rdata | input | 32 | Data word, valid the cycle after a request |
| halted | output | 1 | High once return has executed |
| dbg_sel | input | 4 | Register index for debug read |
| dbg_data | output | 32 | Contents of the selected register |

## Verification
The assertions assume that each memory returns its word exactly one cycle after a request, and that the read data holds while no request is made. The bench memory models update their read data only on a request edge, so they behave this way. The bench also assumes that every program ends in a return before the program counter wraps. Each directed program is short and ends in a return, so fetch addresses always run forward from 0. Data addresses with wide upper bits are logged in full at the port, while the bench memory itself decodes only the low bits.

// File: rtl/lsx_pkg.sv
package lsx_pkg;
  localparam int unsigned XLEN_D = 32;
  localparam int unsigned AW_D   = 20;
  localparam int unsigned RW_D   = 4;

  typedef enum logic [3:0] {
    OP_MUL  = 4'd0,
    OP_ADD  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_LOAD = 4'd4,
    OP_RET  = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_LOAD  = 2'd2,
    ST_HALT  = 2'd3
  } state_e;
endpackage

// File: rtl/lsx_decode.sv
module lsx_decode
  import lsx_pkg::*;
#(
  parameter int unsigned XLEN = XLEN_D,
  parameter int unsigned AW   = AW_D,
  parameter int unsigned RW   = RW_D,
  localparam int unsigned ILEN = 3 * RW + AW
) (
  input  logic [ILEN-1:0] instr,
  output logic [RW-1:0]   dst,
  output op_e             op,
  output logic [RW-1:0]   src,
  output logic [XLEN-1:0] imm_ext
);
  logic [AW-1:0] field;

  // Field order is fixed: destination, operation, source, operand (R2)
  assign dst   = instr[ILEN-1 -: RW];
  assign op    = op_e'(instr[ILEN-RW-1 -: 4]);
  assign src   = instr[AW +: RW];
  assign field = instr[AW-1:0];

  // Two's-complement widening of the operand (R3)
  assign imm_ext = {{(XLEN-AW){field[AW-1]}}, field};
endmodule

// File: rtl/lsx_alu.sv
module lsx_alu
  import lsx_pkg::*;
#(
  parameter int unsigned XLEN = XLEN_D
) (
  input  op_e             op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] result,
  output logic            writes
);
  always_comb begin
    writes = 1'b1;
    result = '0;
    case (op)
      OP_MUL:  result = a * b;
      OP_ADD:  result = a + b;
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      default: writes = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsx_regfile.sv
module lsx_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RW   = 4,
  localparam int unsigned NREG = 1 << RW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RW-1:0]   ra,
  output logic [XLEN-1:0] rdata,
  input  logic [RW-1:0]   rb,
  output logic [XLEN-1:0] rbdata
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : gen_reg
    logic [XLEN-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (we && waddr == RW'(g))      q <= wdata;
    end
    assign regs[g] = q;
  end

  assign rdata  = regs[ra];
  assign rbdata = regs[rb];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(waddr)] == $past(wdata)); // R2
endmodule

// File: rtl/lsx_core.sv
module lsx_core
  import lsx_pkg::*;
#(
  parameter int unsigned XLEN = XLEN_D,
  parameter int unsigned AW   = AW_D,
  parameter int unsigned RW   = RW_D,
  localparam int unsigned ILEN = 3 * RW + AW
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            imem_req,
  output logic [AW-1:0]   imem_addr,
  input  logic [ILEN-1:0] imem_rdata,
  output logic            dmem_req,
  output logic [AW-1:0]   dmem_addr,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            halted,
  input  logic [RW-1:0]   dbg_sel,
  output logic [XLEN-1:0] dbg_data
);
  state_e          state, state_nx;
  logic [AW-1:0]   pc;
  logic [RW-1:0]   dst, src, load_dst;
  op_e             op;
  logic [XLEN-1:0] imm_ext, src_val, alu_out, wdata;
  logic            alu_wr, we, advance;
  logic [RW-1:0]   waddr;

  lsx_decode #(.XLEN(XLEN), .AW(AW), .RW(RW)) u_dec (
    .instr(imem_rdata), .dst(dst), .op(op), .src(src), .imm_ext(imm_ext)
  );

  lsx_alu #(.XLEN(XLEN)) u_alu (
    .op(op), .a(src_val), .b(imm_ext), .result(alu_out), .writes(alu_wr)
  );

  lsx_regfile #(.XLEN(XLEN), .RW(RW)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .ra(src), .rdata(src_val), .rb(dbg_sel), .rbdata(dbg_data)
  );

  always_comb begin
    state_nx = state;
    we       = 1'b0;
    waddr    = dst;
    wdata    = alu_out;
    advance  = 1'b0;
    case (state)
      ST_FETCH: state_nx = ST_EXEC;
      ST_EXEC: begin
        if (op == OP_RET) begin
          state_nx = ST_HALT;
        end else if (op == OP_LOAD) begin
          state_nx = ST_LOAD;
        end else begin
          we       = alu_wr;
          advance  = 1'b1;
          state_nx = ST_FETCH;
        end
      end
      ST_LOAD: begin
        we       = 1'b1;
        waddr    = load_dst;
        wdata    = dmem_rdata;
        advance  = 1'b1;
        state_nx = ST_FETCH;
      end
      default: state_nx = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_FETCH;
      pc       <= '0;
      load_dst <= '0;
    end else begin
      state <= state_nx;
      if (advance) pc <= pc + 1'b1;
      if (state == ST_EXEC) load_dst <= dst;
    end
  end

  assign imem_req  = (state == ST_FETCH);
  assign imem_addr = pc;
  assign dmem_req  = (state == ST_EXEC) && (op == OP_LOAD);
  assign dmem_addr = src_val[AW-1:0];
  assign halted    = (state == ST_HALT);

  // Checker-side fetch tracking
  logic [AW-1:0] last_fetch;
  logic          seen_fetch;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_fetch <= '0;
      seen_fetch <= 1'b0;
    end else if (imem_req) begin
      last_fetch <= imem_addr;
      seen_fetch <= 1'b1;
    end
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R8
  AST_QUIET_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !imem_req && !dmem_req); // R8
  AST_LOAD_WB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_req |=> !imem_req && !dmem_req); // R7
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_req && seen_fetch) |-> imem_addr == AW'(last_fetch + 1'b1)); // R10
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(imem_req && dmem_req)); // R10
endmodule

// File: tb/test_lsx_core.sv
module test_lsx_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_req, dmem_req, halted;
  logic [19:0] imem_addr, dmem_addr;
  logic [31:0] imem_rdata, dmem_rdata, dbg_data;
  logic [3:0]  dbg_sel = '0;

  int tests = 0, fails = 0;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int          fcnt, dcnt;
  logic        fbad;
  logic [19:0] flast;
  logic [19:0] dlog [8];

  always #10 clk = ~clk;

  lsx_core i_lsx_core (
    .clk(clk), .rst_n(rst_n), .imem_req(imem_req), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .dmem_req(dmem_req), .dmem_addr(dmem_addr),
    .dmem_rdata(dmem_rdata), .halted(halted), .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= 0; dcnt <= 0; fbad <= 1'b0; flast <= '0;
      imem_rdata <= '0; dmem_rdata <= '0;
    end else begin
      if (imem_req) begin
        imem_rdata <= imem[imem_addr[5:0]];
        if (fcnt != 0 && imem_addr != flast + 20'd1) fbad <= 1'b1;
        flast <= imem_addr;
        fcnt  <= fcnt + 1;
      end
      if (dmem_req) begin
        dmem_rdata <= dmem[dmem_addr[5:0]];
        if (dcnt < 8) dlog[dcnt[2:0]] <= dmem_addr;
        dcnt <= dcnt + 1;
      end
    end
  end

  function automatic logic [31:0] enc(input int d, input int o, input int s, input logic [19:0] f);
    return {4'(d), 4'(o), 4'(s), f};
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    @(negedge clk);
    dbg_sel = 4'(idx);
    #1 v = dbg_data;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = enc(0, 15, 0, 20'h0);
      dmem[i] = 32'h0;
    end
  endtask

  // Resets, releases, counts cycles until halted
  task automatic run(output int cyc);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    cyc = 0;
    while (cyc < 2000) begin
      @(negedge clk); cyc++;
      if (halted) break;
    end
  endtask

  task automatic t_example();
    int c; logic [31:0] v;
    clear_mem();
    imem[0] = enc(2, 1, 0, 20'd7);
    imem[1] = enc(3, 0, 2, 20'd4);
    imem[2] = enc(4, 1, 3, 20'd16);
    imem[3] = enc(5, 4, 4, 20'h00000);
    imem[4] = enc(1, 1, 5, 20'd1);
    imem[5] = enc(0, 15, 0, 20'h0);
    dmem[44] = 32'h1234_5678;
    run(c);
    check(32'(c), 32'd13, "R10 cycles to halt");
    rd(2, v); check(v, 32'd7, "R5 add");
    rd(3, v); check(v, 32'd28, "R4 mul by 4");
    rd(4, v); check(v, 32'd44, "R5 add address");
    rd(5, v); check(v, 32'h1234_5678, "R7 load data");
    rd(1, v); check(v, 32'h1234_5679, "R2 fields dest/src");
    check(32'(fcnt), 32'd6, "R10 fetch count");
    check(32'(fbad), 32'd0, "R10 fetch sequence");
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk); rst_n = 1'b0;
    #1;
    check(32'(halted), 32'd0, "R1 halted low in reset");
    check(32'(imem_addr), 32'd0, "R1 pc zero");
    for (int i = 0; i < 16; i++) begin
      dbg_sel = 4'(i); #1;
      check(dbg_data, 32'd0, "R1 register cleared");
    end
    @(negedge clk); rst_n = 1'b1;
    #1 check(32'(imem_req), 32'd1, "R1 fetch from 0 after reset");
    check(32'(imem_addr), 32'd0, "R1 first fetch address");
    rd(0, v);
  endtask

  task automatic t_sign();
    int c; logic [31:0] v;
    clear_mem();
    imem[0] = enc(1, 1, 0, 20'hFFFFB);
    imem[1] = enc(2, 0, 1, 20'hFFFFD);
    imem[2] = enc(3, 1, 1, 20'h7FFFF);
    imem[3] = enc(4, 1, 0, 20'h80000);
    imem[4] = enc(0, 15, 0, 20'h0);
    run(c);
    rd(1, v); check(v, 32'hFFFF_FFFB, "R3 negative constant");
    rd(2, v); check(v, 32'd15, "R3 R4 negative multiply");
    rd(3, v); check(v, 32'd524282, "R3 max positive");
    rd(4, v); check(v, 32'hFFF8_0000, "R3 most negative");
  endtask

  task automatic t_logic();
    int c; logic [31:0] v; logic [63:0] p;
    clear_mem();
    imem[0] = enc(1, 3, 0, 20'hFFFFF);
    imem[1] = enc(2, 2, 1, 20'h00F0F);
    imem[2] = enc(3, 3, 2, 20'h80000);
    imem[3] = enc(5, 1, 0, 20'h7FFFF);
    imem[4] = enc(6, 0, 5, 20'h7FFFF);
    imem[5] = enc(0, 15, 0, 20'h0);
    run(c);
    p = 64'd524287 * 64'd524287;
    rd(1, v); check(v, 32'hFFFF_FFFF, "R6 or with -1");
    rd(2, v); check(v, 32'h0000_0F0F, "R6 and");
    rd(3, v); check(v, 32'hFFF8_0F0F, "R6 or sign bit");
    rd(6, v); check(v, p[31:0], "R4 low product bits");
  endtask

  task automatic t_load();
    int c; logic [31:0] v;
    clear_mem();
    imem[0] = enc(1, 1, 0, 20'hFFFFF);
    imem[1] = enc(2, 4, 1, 20'h00005);
    imem[2] = enc(3, 1, 0, 20'd8);
    imem[3] = enc(4, 4, 3, 20'h0003A);
    imem[4] = enc(0, 15, 0, 20'h0);
    dmem[63] = 32'hCAFE_0001;
    dmem[8]  = 32'h0BAD_F00D;
    dmem[5]  = 32'h5555_5555;
    run(c);
    check(32'(c), 32'd12, "R10 load takes three cycles");
    check(32'(dcnt), 32'd2, "R7 data requests");
    check(32'(dlog[0]), 32'hFFFFF, "R7 low 20 bits of source");
    check(32'(dlog[1]), 32'd8, "R7 operand ignored");
    rd(2, v); check(v, 32'hCAFE_0001, "R7 load wide address");
    rd(4, v); check(v, 32'h0BAD_F00D, "R7 load small address");
  endtask

  task automatic t_nop();
    int c; logic [31:0] v;
    clear_mem();
    imem[0] = enc(1, 1, 0, 20'd3);
    imem[1] = enc(1, 7, 0, 20'd99);
    imem[2] = enc(1, 14, 0, 20'd5);
    imem[3] = enc(2, 5, 1, 20'd1);
    imem[4] = enc(3, 1, 1, 20'd1);
    imem[5] = enc(0, 15, 0, 20'h0);
    run(c);
    check(32'(c), 32'd12, "R9 nop timing");
    rd(1, v); check(v, 32'd3, "R9 target untouched");
    rd(2, v); check(v, 32'd0, "R9 other target untouched");
    rd(3, v); check(v, 32'd4, "R9 pc advances past nop");
    check(32'(dcnt), 32'd0, "R9 no data access");
  endtask

  task automatic t_halt();
    int c, f0, d0; logic [31:0] v;
    clear_mem();
    imem[0] = enc(1, 1, 0, 20'd9);
    imem[1] = enc(0, 15, 0, 20'h0);
    imem[2] = enc(6, 1, 0, 20'd55);
    imem[3] = enc(7, 4, 0, 20'h0);
    run(c);
    check(32'(c), 32'd4, "R8 halt timing");
    f0 = fcnt; d0 = dcnt;
    for (int i = 0; i < 10; i++) @(negedge clk);
    check(32'(halted), 32'd1, "R8 halted holds");
    check(32'(fcnt - f0), 32'd0, "R8 no fetch after halt");
    check(32'(dcnt - d0), 32'd0, "R8 no data access after halt");
    rd(6, v); check(v, 32'd0, "R8 later instruction skipped");
    rd(1, v); check(v, 32'd9, "R8 earlier instruction kept");
  endtask

  initial begin
    clear_mem();
    t_example();
    t_reset();
    t_sign();
    t_logic();
    t_load();
    t_nop();
    t_halt();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #4000000;
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule